// File: doc/BRIEF.md
# Serial Command and Status Slave

This block is the control-port front end of a voice store-and-replay engine. A host controller talks to it over four wires: an active-low chip select, a serial clock, a command data line into the block and a reply data line out of it. Each transaction opens with a command byte, followed by as many data bytes as that command needs, or by one reply byte that the block shifts out. The block samples all three inputs with its own faster system clock.

It keeps the 8-bit mode register and builds the 8-bit status byte. The status byte carries an interrupt flag, a buffer-empty bit, an idle bit and a 5-bit power level that comes in on a port. Decoded page and wait commands go out as one-cycle strobes to a separate sequencer, which reports busy and buffer-empty back. The interrupt request is modelled as an open-drain pull-down enable. The reply line is modelled as a data bit with a separate drive enable.

Top module: `serial_cmd_slave`

## Requirements
- R1: Bits are taken on rising serial-clock edges while chip select is low, most significant bit first; a byte acts only when its eighth bit arrives.
- R2: Raising chip select before a byte or a command's data is complete discards it, and the next transaction starts with a fresh command byte.
- R3: Command 60h followed by one byte loads the mode register with that byte and bits 2..0 forced to 0. Bit 7 of the mode register is the interrupt enable.
- R4: Command 61h returns one reply byte: bit 7 interrupt flag, bit 6 buffer empty, bit 5 idle, bits 4..0 power level. The bits are shifted MSB first. Bit 7 is valid before the first rising edge after the command byte, and each later bit is valid before the next rising edge.
- R5: The reply enable output is 1 only while the reply byte is being shifted out and 0 otherwise.
- R6: The interrupt flag sets when the buffer-empty bit or the idle bit (idle = not seqBusy) goes from 0 to 1.
- R7: A complete status read that reported the flag as 1 clears the flag.
- R8: The interrupt pull-down is active exactly when the flag and mode bit 7 are both 1.
- R9: Command 62h with two data bytes issues one single-cycle cmdValid with cmdWait = 0 and cmdPage = {first byte bits 3..0, second byte}.
- R10: Command 63h issues one single-cycle cmdValid with cmdWait = 1 as soon as the command byte arrives.
- R11: Command 01h clears the mode register and the flag, reads back buffer-empty and idle as 1, and pulses haltReq. This transition never sets the flag.
- R12: Unknown command codes, and any bytes that follow a complete command inside the same chip-select window, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from host |
| cmdIn | input | 1 | Serial command data from host |
| replyData | output | 1 | Serial reply data bit |
| replyEn | output | 1 | Drive enable for the reply line |
| irqPullLow | output | 1 | 1 = pull the open-drain interrupt line low |
| modeReg | output | 8 | Current mode register |
| powerLevel | input | 5 | Input power level for the status byte |
| seqBusy | input | 1 | Sequencer is executing a command |
| seqBufEmpty | input | 1 | Sequencer command buffer is empty |
| cmdValid | output | 1 | One-cycle strobe for a new page or wait command |
| cmdWait | output | 1 | 1 = wait command, 0 = page command |
| cmdPage | output | 12 | Page number for a page command |
| haltReq | output | 1 | One-cycle request to halt and flush the sequencer |

## Verification
The bench runs random mixes of mode writes, status reads, page and wait commands and sequencer status changes. These are checked against a bench model of the mode register and the flag, so that ordering effects between flag sets and read-clears show up. Directed cases cover the remaining corners:
- Transfers cut short at several bit positions tell a true abort apart from late commit.
- Trailing bytes after a complete command, and unknown codes, tell ignore-until-deselect apart from re-decoding.
- A general reset issued while the sequencer is busy tells preset-without-flag apart from an ordinary idle rise.

// File: rtl/scif_pkg.sv
package scif_pkg;
  localparam logic [7:0] CODE_RESET = 8'h01;
  localparam logic [7:0] CODE_MODE  = 8'h60;
  localparam logic [7:0] CODE_STAT  = 8'h61;
  localparam logic [7:0] CODE_PAGE  = 8'h62;
  localparam logic [7:0] CODE_WAIT  = 8'h63;

  // Strobes from control to datapath; all single-cycle except replyActive
  typedef struct packed {
    logic genReset;
    logic modeWr;
    logic statusLoad;
    logic statusDone;
    logic pageHiWr;
    logic pageIssue;
    logic waitIssue;
    logic replyActive;
  } ctrlStrobe_t;
endpackage

// File: rtl/scif_rx.sv
module scif_rx #(
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csN,
  input  logic              sclk,
  input  logic              sdi,
  output logic              csActive,
  output logic              sclkRise,
  output logic              byteDone,
  output logic [BYTE_W-1:0] byteVal
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic [SYNC_STAGES-1:0] csSync, clkSync, datSync;
  logic sclkPrev;
  logic [BYTE_W-2:0] shReg;
  logic [CNT_W-1:0] bitCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csSync  <= '1;
      clkSync <= '0;
      datSync <= '0;
    end else begin
      csSync  <= {csSync[SYNC_STAGES-2:0], csN};
      clkSync <= {clkSync[SYNC_STAGES-2:0], sclk};
      datSync <= {datSync[SYNC_STAGES-2:0], sdi};
    end
  end

  logic sclkS, dinS;
  assign sclkS    = clkSync[SYNC_STAGES-1];
  assign dinS     = datSync[SYNC_STAGES-1];
  assign csActive = ~csSync[SYNC_STAGES-1];
  assign sclkRise = csActive & sclkS & ~sclkPrev;
  assign byteDone = sclkRise && (bitCnt == CNT_W'(BYTE_W-1));
  assign byteVal  = {shReg, dinS};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclkPrev <= 1'b0;
      shReg    <= '0;
      bitCnt   <= '0;
    end else begin
      sclkPrev <= sclkS;
      if (!csActive) begin
        bitCnt <= '0;
      end else if (sclkRise) begin
        shReg  <= {shReg[BYTE_W-3:0], dinS};
        bitCnt <= byteDone ? '0 : bitCnt + 1'b1;
      end
    end
  end

  // R1: a byte can only complete inside an open chip-select window
  assert_byte_in_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !csActive |=> bitCnt == '0);
endmodule

// File: rtl/scif_ctrl.sv
module scif_ctrl
  import scif_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csActive,
  input  logic              byteDone,
  input  logic [BYTE_W-1:0] byteVal,
  output ctrlStrobe_t       strb
);
  typedef enum logic [2:0] {ST_CMD, ST_MODE, ST_PGHI, ST_PGLO, ST_REPLY, ST_DONE} state_e;
  state_e state, nxtState;

  always_comb begin
    nxtState = state;
    strb = '0;
    strb.replyActive = (state == ST_REPLY);
    if (byteDone) begin
      case (state)
        ST_CMD: begin
          nxtState = ST_DONE;
          case (byteVal)
            CODE_RESET: strb.genReset = 1'b1;
            CODE_MODE:  nxtState = ST_MODE;
            CODE_STAT:  begin strb.statusLoad = 1'b1; nxtState = ST_REPLY; end
            CODE_PAGE:  nxtState = ST_PGHI;
            CODE_WAIT:  strb.waitIssue = 1'b1;
            default:    nxtState = ST_DONE;
          endcase
        end
        ST_MODE:  begin strb.modeWr = 1'b1;     nxtState = ST_DONE; end
        ST_PGHI:  begin strb.pageHiWr = 1'b1;   nxtState = ST_PGLO; end
        ST_PGLO:  begin strb.pageIssue = 1'b1;  nxtState = ST_DONE; end
        ST_REPLY: begin strb.statusDone = 1'b1; nxtState = ST_DONE; end
        default:  nxtState = ST_DONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         state <= ST_CMD;
    else if (!csActive) state <= ST_CMD;
    else                state <= nxtState;
  end

  // R2: deselect always ends a reply and returns to command decode
  assert_abort_ends_reply_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !csActive |=> !strb.replyActive && state == ST_CMD);
  // R12: once a command is complete, no further byte produces an action
  assert_done_is_inert_R12: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_DONE |-> !(strb.genReset | strb.modeWr | strb.statusLoad |
                           strb.pageHiWr | strb.pageIssue | strb.waitIssue));
  // R1: at most one action per committed byte
  assert_one_action_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.genReset, strb.modeWr, strb.statusLoad, strb.statusDone,
              strb.pageHiWr, strb.pageIssue, strb.waitIssue}));
endmodule

// File: rtl/scif_dp.sv
module scif_dp
  import scif_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int PAGE_W   = 12,
  parameter int PWR_W    = 5,
  parameter int HOLD_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobe_t       strb,
  input  logic              sclkRise,
  input  logic [BYTE_W-1:0] byteVal,
  input  logic              seqBufEmpty,
  input  logic              seqBusy,
  input  logic [PWR_W-1:0]  powerLevel,
  output logic [BYTE_W-1:0] modeReg,
  output logic              replyData,
  output logic              irqPullLow,
  output logic              cmdValid,
  output logic              cmdWait,
  output logic [PAGE_W-1:0] cmdPage,
  output logic              haltReq
);
  localparam int HI_W   = PAGE_W - BYTE_W;
  localparam int STAT_W = PWR_W + 3;
  localparam int HOLD_W = $clog2(HOLD_CYC + 1);

  logic [BYTE_W-1:0] modeQ;
  logic [HI_W-1:0]   pageHi;
  logic [STAT_W-1:0] replySh;
  logic [HOLD_W-1:0] holdCnt;
  logic flagQ, emptyQ, idleQ, snapFlag;
  logic holding, riseAny;

  assign holding = (holdCnt != '0);
  assign riseAny = ((~emptyQ & seqBufEmpty) | (~idleQ & ~seqBusy)) & ~holding & ~strb.genReset;

  // Mode, status bits and interrupt flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modeQ <= '0; flagQ <= 1'b0; emptyQ <= 1'b1; idleQ <= 1'b1; holdCnt <= '0;
    end else if (strb.genReset) begin
      modeQ <= '0; flagQ <= 1'b0; emptyQ <= 1'b1; idleQ <= 1'b1;
      holdCnt <= HOLD_W'(HOLD_CYC);
    end else begin
      if (strb.modeWr) modeQ <= {byteVal[BYTE_W-1:3], 3'b000};
      if (holding) begin
        holdCnt <= holdCnt - 1'b1;
      end else begin
        emptyQ <= seqBufEmpty;
        idleQ  <= ~seqBusy;
      end
      flagQ <= riseAny | (flagQ & ~(strb.statusDone & snapFlag));
    end
  end

  // Reply shifter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      replySh <= '0; snapFlag <= 1'b0;
    end else if (strb.statusLoad) begin
      replySh  <= {flagQ, emptyQ, idleQ, powerLevel};
      snapFlag <= flagQ;
    end else if (strb.replyActive && sclkRise) begin
      replySh <= {replySh[STAT_W-2:0], 1'b0};
    end
  end

  // Sequencer hand-off
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pageHi <= '0; cmdValid <= 1'b0; cmdWait <= 1'b0; cmdPage <= '0; haltReq <= 1'b0;
    end else begin
      if (strb.pageHiWr) pageHi <= byteVal[HI_W-1:0];
      cmdValid <= strb.pageIssue | strb.waitIssue;
      haltReq  <= strb.genReset;
      if (strb.pageIssue) begin cmdWait <= 1'b0; cmdPage <= {pageHi, byteVal}; end
      else if (strb.waitIssue) cmdWait <= 1'b1;
    end
  end

  assign modeReg    = modeQ;
  assign replyData  = replySh[STAT_W-1];
  assign irqPullLow = flagQ & modeQ[BYTE_W-1];

  assert_mode_low_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    modeQ[2:0] == 3'b000);
  assert_flag_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flagQ) |-> $rose(emptyQ) || $rose(idleQ));
  assert_reset_effect_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(strb.genReset) |-> modeQ == '0 && !flagQ && emptyQ && idleQ && haltReq);
  assert_cmd_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmdValid |=> !cmdValid);
endmodule

// File: rtl/serial_cmd_slave.sv
module serial_cmd_slave
  import scif_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PAGE_W      = 12,
  parameter int PWR_W       = 5,
  parameter int HOLD_CYC    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csN,
  input  logic              sclk,
  input  logic              cmdIn,
  output logic              replyData,
  output logic              replyEn,
  output logic              irqPullLow,
  output logic [7:0]        modeReg,
  input  logic [PWR_W-1:0]  powerLevel,
  input  logic              seqBusy,
  input  logic              seqBufEmpty,
  output logic              cmdValid,
  output logic              cmdWait,
  output logic [PAGE_W-1:0] cmdPage,
  output logic              haltReq
);
  localparam int BYTE_W = 8;

  logic csActive, sclkRise, byteDone;
  logic [BYTE_W-1:0] byteVal;
  ctrlStrobe_t strb;

  scif_rx #(.SYNC_STAGES(SYNC_STAGES), .BYTE_W(BYTE_W)) rx_i (
    .clk(clk), .rst_n(rst_n), .csN(csN), .sclk(sclk), .sdi(cmdIn),
    .csActive(csActive), .sclkRise(sclkRise), .byteDone(byteDone), .byteVal(byteVal));

  scif_ctrl #(.BYTE_W(BYTE_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .csActive(csActive), .byteDone(byteDone),
    .byteVal(byteVal), .strb(strb));

  scif_dp #(.BYTE_W(BYTE_W), .PAGE_W(PAGE_W), .PWR_W(PWR_W), .HOLD_CYC(HOLD_CYC)) dp_i (
    .clk(clk), .rst_n(rst_n), .strb(strb), .sclkRise(sclkRise), .byteVal(byteVal),
    .seqBufEmpty(seqBufEmpty), .seqBusy(seqBusy), .powerLevel(powerLevel),
    .modeReg(modeReg), .replyData(replyData), .irqPullLow(irqPullLow),
    .cmdValid(cmdValid), .cmdWait(cmdWait), .cmdPage(cmdPage), .haltReq(haltReq));

  assign replyEn = strb.replyActive;
endmodule

// File: tb/serial_cmd_slave_tb_top.sv
module serial_cmd_slave_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, csN, sclk, cmdIn;
  logic replyData, replyEn, irqPullLow, cmdValid, cmdWait, haltReq;
  logic [7:0] modeReg;
  logic [4:0] powerLevel;
  logic seqBusy, seqBufEmpty;
  logic [11:0] cmdPage;

  serial_cmd_slave dut_i (
    .clk(clk), .rst_n(rst_n), .csN(csN), .sclk(sclk), .cmdIn(cmdIn),
    .replyData(replyData), .replyEn(replyEn), .irqPullLow(irqPullLow),
    .modeReg(modeReg), .powerLevel(powerLevel), .seqBusy(seqBusy),
    .seqBufEmpty(seqBufEmpty), .cmdValid(cmdValid), .cmdWait(cmdWait),
    .cmdPage(cmdPage), .haltReq(haltReq));

  int checks = 0, errors = 0;
  bit done = 0;

  // Sequencer model: obeys halt, otherwise applies bench requests
  logic reqE = 1'b1, reqB = 1'b0, reqTog = 1'b0, lastTog = 1'b0;
  always @(posedge clk) begin
    lastTog <= reqTog;
    if (haltReq) begin seqBufEmpty <= 1'b1; seqBusy <= 1'b0; end
    else if (reqTog != lastTog) begin seqBufEmpty <= reqE; seqBusy <= reqB; end
  end

  int cmdCnt = 0, haltCnt = 0;
  logic [11:0] lastPage = '0;
  logic lastWait = 1'b0;
  always @(posedge clk) begin
    if (cmdValid) begin cmdCnt <= cmdCnt + 1; lastPage <= cmdPage; lastWait <= cmdWait; end
    if (haltReq) haltCnt <= haltCnt + 1;
  end

  // Bench model
  logic [7:0] expMode = 8'h00;
  logic expFlag = 1'b0, expEmpty = 1'b1, expIdle = 1'b1;

  function automatic logic [7:0] expStatus(input logic f, input logic e, input logic i,
                                           input logic [4:0] p);
    return {f, e, i, p};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xbit(input logic b, output logic r, output logic en);
    sclk = 1'b0; cmdIn = b; waitClk(4);
    r = replyData; en = replyEn;
    sclk = 1'b1; waitClk(4);
  endtask

  task automatic xbits(input logic [7:0] v, input int n, output logic [7:0] r,
                       output bit enAll, output bit enAny);
    logic b, e;
    r = '0; enAll = 1; enAny = 0;
    for (int i = 7; i > 7 - n; i--) begin
      xbit(v[i], b, e);
      r[i] = b; enAll &= e; enAny |= e;
    end
  endtask

  task automatic csOn;  csN = 1'b0; waitClk(4); endtask
  task automatic csOff; sclk = 1'b0; waitClk(2); csN = 1'b1; waitClk(8); endtask

  task automatic sendByte(input logic [7:0] v);
    logic [7:0] r; bit a, y;
    xbits(v, 8, r, a, y);
  endtask

  task automatic doMode(input logic [7:0] v);
    csOn; sendByte(8'h60); sendByte(v); csOff;
    expMode = {v[7:3], 3'b000};
    chk(modeReg == expMode, "R3 mode write", modeReg, expMode);
  endtask

  task automatic doRead(input logic [4:0] pwr, input string tag);
    logic [7:0] r, e; bit cmdAll, cmdAny, repAll, repAny;
    powerLevel = pwr;
    e = expStatus(expFlag, expEmpty, expIdle, pwr);
    csOn; xbits(8'h61, 8, r, cmdAll, cmdAny); xbits(8'h00, 8, r, repAll, repAny); csOff;
    chk(r == e, {tag, " R4 status reply"}, r, e);
    chk(repAll && !cmdAny, "R5 reply enable window", {repAll, cmdAny}, 2'b10);
    chk(!replyEn, "R5 reply enable off after read", replyEn, 0);
    if (e[7]) expFlag = 1'b0;
  endtask

  task automatic doPage(input logic [7:0] hi, input logic [7:0] lo);
    int c0; logic [11:0] e;
    c0 = cmdCnt; e = {hi[3:0], lo};
    csOn; sendByte(8'h62); sendByte(hi); sendByte(lo); csOff;
    chk(cmdCnt == c0 + 1, "R9 one page strobe", cmdCnt - c0, 1);
    chk(lastPage == e && !lastWait, "R9 page number", {lastWait, lastPage}, e);
  endtask

  task automatic doWait;
    int c0;
    c0 = cmdCnt;
    csOn; sendByte(8'h63); csOff;
    chk(cmdCnt == c0 + 1 && lastWait, "R10 wait strobe", {lastWait, 4'(cmdCnt - c0)}, 5'h11);
  endtask

  task automatic setSeq(input logic e, input logic b);
    if ((!expEmpty && e) || (!expIdle && !b)) expFlag = 1'b1;
    expEmpty = e; expIdle = !b;
    reqE = e; reqB = b; reqTog = ~reqTog;
    waitClk(4);
  endtask

  task automatic chkIrq(input string tag);
    logic e;
    e = expFlag & expMode[7];
    chk(irqPullLow == e, {tag, " R8 irq"}, irqPullLow, e);
  endtask

  task automatic finishRun;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun;
  end

  initial begin
    logic [7:0] r; bit a, y; int c0, h0;
    void'($urandom(32'h5eed));
    rst_n = 1'b0; csN = 1'b1; sclk = 1'b0; cmdIn = 1'b0; powerLevel = 5'd0;
    seqBusy = 1'b0; seqBufEmpty = 1'b1;
    waitClk(5); rst_n = 1'b1; waitClk(5);

    // Reset state
    chk(modeReg == 8'h00, "reset mode", modeReg, 0);
    chk(!irqPullLow && !replyEn && !cmdValid, "reset outputs R5 R8",
        {irqPullLow, replyEn, cmdValid}, 0);

    // R1/R3: MSB-first assembly and low-bit masking
    doMode(8'hA5);
    doMode(8'h5F);
    doRead(5'h15, "R1 basic");

    // R2: aborts mid-byte and mid-command
    csOn; sendByte(8'h60); xbits(8'hFF, 5, r, a, y); csOff;
    chk(modeReg == expMode, "R2 aborted mode byte", modeReg, expMode);
    c0 = cmdCnt;
    csOn; sendByte(8'h62); sendByte(8'h0F); xbits(8'hFF, 3, r, a, y); csOff;
    chk(cmdCnt == c0, "R2 aborted page", cmdCnt - c0, 0);
    csOn; xbits(8'h63, 6, r, a, y); csOff;
    chk(cmdCnt == c0, "R2 aborted command byte", cmdCnt - c0, 0);
    doPage(8'hFA, 8'h3C);

    // R12: unknown code and trailing bytes
    csOn; sendByte(8'h55); sendByte(8'h60); sendByte(8'hF8); csOff;
    chk(modeReg == expMode, "R12 unknown code", modeReg, expMode);
    c0 = cmdCnt;
    csOn; sendByte(8'h63); sendByte(8'h60); sendByte(8'h88); csOff;
    chk(modeReg == expMode && cmdCnt == c0 + 1, "R12 trailing bytes",
        {modeReg, 4'(cmdCnt - c0)}, {expMode, 4'h1});
    doWait;

    // R6/R7/R8: flag set, irq, read-clear
    doMode(8'h80);
    setSeq(1'b0, 1'b1);
    chk(!irqPullLow, "R6 no flag on fall", irqPullLow, 0);
    setSeq(1'b1, 1'b1);
    chkIrq("R6 empty rise");
    doRead(5'h1F, "R7 first");
    chkIrq("R7 cleared");
    doRead(5'h00, "R7 second");
    setSeq(1'b1, 1'b0);
    doMode(8'h00);
    chkIrq("R8 disabled");
    doMode(8'h80);
    chkIrq("R8 enabled");
    doRead(5'h0A, "R7 idle rise");

    // R11: general reset while busy
    doMode(8'hF8);
    setSeq(1'b0, 1'b1);
    h0 = haltCnt;
    csOn; sendByte(8'h01); csOff;
    expMode = 8'h00; expFlag = 1'b0; expEmpty = 1'b1; expIdle = 1'b1;
    reqE = 1'b1; reqB = 1'b0;
    chk(haltCnt == h0 + 1, "R11 halt pulse", haltCnt - h0, 1);
    chk(modeReg == 8'h00 && !irqPullLow, "R11 mode cleared", modeReg, 0);
    doRead(5'h07, "R11 preset");

    // Random mix
    for (int k = 0; k < 60; k++) begin
      case ($urandom % 5)
        0: doMode(8'($urandom));
        1: doRead(5'($urandom), "random");
        2: doPage(8'($urandom), 8'($urandom));
        3: doWait;
        default: setSeq(1'($urandom), 1'($urandom));
      endcase
      chkIrq("random");
    end

    finishRun;
  end
endmodule